// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the management-side endpoint of an Ethernet physical-layer device. It listens to the two-wire management bus: a clock from the station manager (MDC) and a shared data line (MDIO). Through it, software reads and writes a bank of 32 addresses of 16 bits each. Every bit of a frame is sampled on the rising edge of MDC. A frame is a run of ones, a `01` start pattern, a two-bit opcode, a five-bit device address, a five-bit register address, a two-bit bus turnaround, and sixteen data bits. Each field is sent most significant bit first.

The block answers two device addresses. One is its own, taken from five strap pins while reset is held. The other is the broadcast address 00000. On a read it takes over the data line through a separate output enable, so the pad and the tri-state buffer stay outside. On a write it updates the control word. Five addresses are implemented: control, status, two identifier words, and a word that reports the strapped address. Every other address reads as zero and discards writes. A one-cycle strobe tells the link logic when a new auto-negotiation has been requested.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is decoded only when at least 32 consecutive ones precede the `0`,`1` start pattern. With 31 ones the frame is not decoded, and the data line is never driven.
- R2: On a read the line is released (`mdio_oe`=0) during the first turnaround bit. It is driven to 0 during the second turnaround bit, then carries the 16 data bits MSB first. It is released again right after bit 0.
- R3: Frames carrying the strapped device address or address 00000 are served. Frames carrying any other device address get no drive, and their writes change nothing.
- R4: The strap pins are captured while reset is held. Register 25 returns the captured address in bits 4:0, and bit 6 set to 1 when control bit 13 is 0 (10 Mbps selected). All other bits of register 25 read as 0.
- R5: When the captured address is 00000, control bit 10 (isolate) reads as 1 whatever is written.
- R6: The control register (address 0) comes out of reset as 0x3000 (bit 13 speed, bit 12 auto-negotiation enable). Bits 14, 13, 12, 11, 10, 8 and 7 are writable. Bits 6:0 always read 0.
- R7: A write to address 0 with bit 15 set returns the control register to 0x3000, whatever the other bits are. Bit 15 never reads back as 1.
- R8: A write to address 0 with bit 9 set and bit 15 clear raises `aneg_restart` for exactly one MDC cycle, two cycles after the sample of the last data bit. Bit 9 always reads 0.
- R9: The status register (address 1) reads bits 15:11 = 01111, bit 5 = `aneg_done`, bit 3 = 1, bit 2 = `link_up`, bit 0 = 1, and all other bits 0.
- R10: Addresses 2 and 3 return the identifier constants 0x0A5C and 0x63D1 and ignore writes.
- R11: Every address other than 0, 1, 2, 3 and 25 reads 0x0000, and writes to it leave all registers unchanged.
- R12: Opcode `10` is a read and `01` is a write. Opcodes `00` and `11` cause no drive and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_addr | input | 5 | Device address straps, captured during reset |
| link_up | input | 1 | Link state reported in the status register |
| aneg_done | input | 1 | Auto-negotiation completion reported in the status register |
| mdio_in | input | 1 | Data line as seen from the pad |
| mdio_out | output | 1 | Value to drive on the data line |
| mdio_oe | output | 1 | Tri-state enable for the data line |
| aneg_restart | output | 1 | One-cycle request to restart auto-negotiation |

## Verification
The embedded assertions check four things on every cycle. The first driven bit of a read is 0. The line is released only on leaving the data phase. The line is never driven outside a served read. The restart strobe never lasts two cycles. They also check that a soft reset lands the default control word, and that the isolate bit is forced whenever the captured address is zero. Other behaviour shows only in the bench's frame scenarios: the preamble length threshold, the address and opcode filtering, the field masks of the control write, register 25 following the speed bit, and the exact cycle of the restart strobe. The bench checks these against its own model of the register bank, cycle by cycle.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HDR,
    ST_TA,
    ST_DATA
  } fr_state_e;

  localparam int          WORD_W     = 16;
  localparam logic [1:0]  OP_RD      = 2'b10;
  localparam logic [1:0]  OP_WR      = 2'b01;

  localparam int          RA_CTRL    = 0;
  localparam int          RA_STAT    = 1;
  localparam int          RA_ID_HI   = 2;
  localparam int          RA_ID_LO   = 3;
  localparam int          RA_STRAP   = 25;

  localparam int          CB_RESET   = 15;
  localparam int          CB_SPEED   = 13;
  localparam int          CB_ISO     = 10;
  localparam int          CB_RESTART = 9;
  localparam int          SB_SLOW    = 6;

  localparam logic [WORD_W-1:0] CTRL_DEF   = 16'h3000;
  localparam logic [WORD_W-1:0] CTRL_WMASK = 16'h7D80;

endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_mgmt_pkg::*;
#(
  parameter int PHY_W   = 5,
  parameter int RA_W    = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHY_W-1:0]  own_addr,
  input  logic              mdio_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [RA_W-1:0]   reg_addr,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              mdio_out,
  output logic              mdio_oe
);

  localparam int HDR_BITS = 2 + PHY_W + RA_W;
  localparam int CNT_W    = $clog2(HDR_BITS > DATA_W ? HDR_BITS : DATA_W);
  localparam int PCNT_W   = $clog2(PRE_LEN + 1);
  localparam logic [CNT_W-1:0]  HDR_LAST  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0]  DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [PCNT_W-1:0] PRE_FULL  = PCNT_W'(PRE_LEN);

  fr_state_e            state_q, state_d;
  logic [PCNT_W-1:0]    pre_q, pre_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [HDR_BITS-2:0]  hdr_q, hdr_d;
  logic [RA_W-1:0]      ra_q, ra_d;
  logic                 rd_q, rd_d;
  logic                 wok_q, wok_d;
  logic [DATA_W-1:0]    dsr_q, dsr_d;
  logic                 out_q, out_d;
  logic                 oe_q, oe_d;
  logic                 wstb_q, wstb_d;
  logic [DATA_W-1:0]    wdat_q, wdat_d;

  logic [HDR_BITS-1:0]  hdr_full;
  logic [1:0]           hdr_op;
  logic [PHY_W-1:0]     hdr_phy;
  logic                 addr_hit;

  assign hdr_full = {hdr_q, mdio_in};
  assign hdr_op   = hdr_full[HDR_BITS-1 -: 2];
  assign hdr_phy  = hdr_full[RA_W +: PHY_W];
  assign addr_hit = (hdr_phy == own_addr) || (hdr_phy == '0);

  always_comb begin
    state_d = state_q;
    pre_d   = pre_q;
    cnt_d   = cnt_q;
    hdr_d   = hdr_q;
    ra_d    = ra_q;
    rd_d    = rd_q;
    wok_d   = wok_q;
    dsr_d   = dsr_q;
    out_d   = out_q;
    oe_d    = oe_q;
    wstb_d  = 1'b0;
    wdat_d  = wdat_q;
    unique case (state_q)
      ST_IDLE: begin
        if (mdio_in) begin
          if (pre_q != PRE_FULL) pre_d = pre_q + 1'b1;
        end else begin
          pre_d = '0;
          if (pre_q == PRE_FULL) state_d = ST_START;
        end
      end
      ST_START: begin
        cnt_d   = '0;
        state_d = mdio_in ? ST_HDR : ST_IDLE;
      end
      ST_HDR: begin
        hdr_d = hdr_full[HDR_BITS-2:0];
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == HDR_LAST) begin
          state_d = ST_TA;
          cnt_d   = '0;
          ra_d    = hdr_full[RA_W-1:0];
          rd_d    = addr_hit && (hdr_op == OP_RD);
          wok_d   = addr_hit && (hdr_op == OP_WR);
          oe_d    = 1'b0;
        end
      end
      ST_TA: begin
        if (cnt_q == '0) begin
          cnt_d = 1'b1;
          if (rd_q) begin
            oe_d  = 1'b1;
            out_d = 1'b0;
          end
        end else begin
          state_d = ST_DATA;
          cnt_d   = '0;
          dsr_d   = rd_data;
          out_d   = rd_data[DATA_W-1];
        end
      end
      ST_DATA: begin
        dsr_d = {dsr_q[DATA_W-2:0], mdio_in};
        out_d = dsr_q[DATA_W-2];
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == DATA_LAST) begin
          state_d = ST_IDLE;
          pre_d   = '0;
          oe_d    = 1'b0;
          wstb_d  = wok_q;
          wdat_d  = {dsr_q[DATA_W-2:0], mdio_in};
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pre_q   <= '0;
      cnt_q   <= '0;
      hdr_q   <= '0;
      ra_q    <= '0;
      rd_q    <= 1'b0;
      wok_q   <= 1'b0;
      dsr_q   <= '0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
      wstb_q  <= 1'b0;
      wdat_q  <= '0;
    end else begin
      state_q <= state_d;
      pre_q   <= pre_d;
      cnt_q   <= cnt_d;
      hdr_q   <= hdr_d;
      ra_q    <= ra_d;
      rd_q    <= rd_d;
      wok_q   <= wok_d;
      dsr_q   <= dsr_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
      wstb_q  <= wstb_d;
      wdat_q  <= wdat_d;
    end
  end

  assign reg_addr = ra_q;
  assign wr_stb   = wstb_q;
  assign wr_data  = wdat_q;
  assign mdio_out = out_q;
  assign mdio_oe  = oe_q;

  // R2
  ta_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !out_q);

  // R2
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> ($past(state_q) == ST_DATA));

  // R3
  oe_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> rd_q);

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_mgmt_pkg::*;
#(
  parameter int                PHY_W   = 5,
  parameter int                RA_W    = 5,
  parameter logic [WORD_W-1:0] ID_HI   = 16'h0A5C,
  parameter logic [WORD_W-1:0] ID_LO   = 16'h63D1,
  parameter logic [4:0]        ABILITY = 5'b01111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHY_W-1:0]  own_addr,
  input  logic              link_up,
  input  logic              aneg_done,
  input  logic [RA_W-1:0]   rd_addr,
  input  logic              wr_stb,
  input  logic [RA_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              aneg_restart
);

  logic [WORD_W-1:0] ctrl_q, ctrl_d;
  logic              rst_pulse_q, rst_pulse_d;
  logic [WORD_W-1:0] ctrl_view;
  logic [WORD_W-1:0] stat_word;
  logic [WORD_W-1:0] strap_word;
  logic              hit_ctrl;

  always_comb begin
    ctrl_view = ctrl_q;
    if (own_addr == '0) ctrl_view[CB_ISO] = 1'b1;
  end

  assign stat_word = {ABILITY, 5'b00000, aneg_done, 1'b0, 1'b1, link_up, 1'b0, 1'b1};

  always_comb begin
    strap_word              = '0;
    strap_word[SB_SLOW]     = ~ctrl_q[CB_SPEED];
    strap_word[PHY_W-1:0]   = own_addr;
  end

  always_comb begin
    case (rd_addr)
      RA_W'(RA_CTRL):  rd_data = ctrl_view;
      RA_W'(RA_STAT):  rd_data = stat_word;
      RA_W'(RA_ID_HI): rd_data = ID_HI;
      RA_W'(RA_ID_LO): rd_data = ID_LO;
      RA_W'(RA_STRAP): rd_data = strap_word;
      default:         rd_data = '0;
    endcase
  end

  assign hit_ctrl = wr_stb && (wr_addr == RA_W'(RA_CTRL));

  always_comb begin
    ctrl_d      = ctrl_q;
    rst_pulse_d = 1'b0;
    if (hit_ctrl) begin
      if (wr_data[CB_RESET]) begin
        ctrl_d = CTRL_DEF;
      end else begin
        ctrl_d      = wr_data & CTRL_WMASK;
        rst_pulse_d = wr_data[CB_RESTART];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= CTRL_DEF;
      rst_pulse_q <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_d;
      rst_pulse_q <= rst_pulse_d;
    end
  end

  assign aneg_restart = rst_pulse_q;

  // R7
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_addr == RA_W'(RA_CTRL)) && wr_data[CB_RESET]) |=> (ctrl_q == CTRL_DEF));

  // R8
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aneg_restart |=> !aneg_restart);

  // R5
  iso_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_addr == '0) |-> ctrl_view[CB_ISO]);

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_mgmt_pkg::*;
#(
  parameter int PHY_W   = 5,
  parameter int RA_W    = 5,
  parameter int PRE_LEN = 32
) (
  input  logic             mdc,
  input  logic             rst_n,
  input  logic [PHY_W-1:0] strap_addr,
  input  logic             link_up,
  input  logic             aneg_done,
  input  logic             mdio_in,
  output logic             mdio_out,
  output logic             mdio_oe,
  output logic             aneg_restart
);

  logic             rs_meta_q, rs_sync_q;
  logic [PHY_W-1:0] own_q;
  logic [RA_W-1:0]  reg_addr;
  logic             wr_stb;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] rd_data;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_sync_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_sync_q <= rs_meta_q;
    end
  end

  always_ff @(posedge mdc) begin
    if (!rs_sync_q) own_q <= strap_addr;
  end

  mdio_frame_fsm #(
    .PHY_W   (PHY_W),
    .RA_W    (RA_W),
    .DATA_W  (WORD_W),
    .PRE_LEN (PRE_LEN)
  ) u_frame (
    .clk      (mdc),
    .rst_n    (rs_sync_q),
    .own_addr (own_q),
    .mdio_in  (mdio_in),
    .rd_data  (rd_data),
    .reg_addr (reg_addr),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe)
  );

  mdio_reg_bank #(
    .PHY_W (PHY_W),
    .RA_W  (RA_W)
  ) u_bank (
    .clk          (mdc),
    .rst_n        (rs_sync_q),
    .own_addr     (own_q),
    .link_up      (link_up),
    .aneg_done    (aneg_done),
    .rd_addr      (reg_addr),
    .wr_stb       (wr_stb),
    .wr_addr      (reg_addr),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .aneg_restart (aneg_restart)
  );

endmodule

// File: tb/mdio_mgmt_slave_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_tb_top;

  logic       mdc = 1'b0;
  logic       rst_n;
  logic [4:0] strap_addr;
  logic       link_up;
  logic       aneg_done;
  logic       mdio_in;
  logic       mdio_out;
  logic       mdio_oe;
  logic       aneg_restart;

  int    checks = 0;
  int    errors = 0;
  logic  chk_en = 1'b0;
  logic  done   = 1'b0;
  logic  exp_oe = 1'b0;
  logic  exp_out = 1'b0;
  logic  exp_rst = 1'b0;
  string cur_req = "R2";

  logic [15:0] m_ctrl;
  logic [4:0]  m_strap;
  logic [15:0] got;

  always #2 mdc = ~mdc;

  mdio_mgmt_slave dut_i (
    .mdc          (mdc),
    .rst_n        (rst_n),
    .strap_addr   (strap_addr),
    .link_up      (link_up),
    .aneg_done    (aneg_done),
    .mdio_in      (mdio_in),
    .mdio_out     (mdio_out),
    .mdio_oe      (mdio_oe),
    .aneg_restart (aneg_restart)
  );

  function automatic logic [15:0] m_read(input logic [4:0] a);
    case (a)
      5'd0:    m_read = m_ctrl | ((m_strap == 5'd0) ? 16'h0400 : 16'h0000);
      5'd1:    m_read = 16'h7809 | (16'(aneg_done) << 5) | (16'(link_up) << 2);
      5'd2:    m_read = 16'h0A5C;
      5'd3:    m_read = 16'h63D1;
      5'd25:   m_read = {9'b0, ~m_ctrl[13], 1'b0, m_strap};
      default: m_read = 16'h0000;
    endcase
  endfunction

  always @(negedge mdc) begin
    if (chk_en) begin
      checks++;
      if ((mdio_oe !== exp_oe) || (exp_oe && (mdio_out !== exp_out)) || (aneg_restart !== exp_rst)) begin
        errors++;
        $display("FAIL %s per-cycle: oe=%b out=%b restart=%b, expected oe=%b out=%b restart=%b",
                 cur_req, mdio_oe, mdio_out, aneg_restart, exp_oe, exp_out, exp_rst);
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic oe, input logic ou, input logic rs);
    @(posedge mdc);
    #1;
    mdio_in = b;
    exp_oe  = oe;
    exp_out = ou;
    exp_rst = rs;
  endtask

  task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [15:0] wd, input logic live,
                       input string req, output logic [15:0] rd);
    logic [15:0] rv;
    logic hit, is_rd, is_wr, rs_ev;
    cur_req = req;
    hit   = (phy == m_strap) || (phy == 5'd0);
    is_rd = live && hit && (op == 2'b10);
    is_wr = live && hit && (op == 2'b01);
    rv    = m_read(ra);
    rd    = 16'h0;
    for (int i = 0; i < pre; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(op[1], 1'b0, 1'b0, 1'b0);
    step(op[0], 1'b0, 1'b0, 1'b0);
    for (int i = 4; i >= 0; i--) step(phy[i], 1'b0, 1'b0, 1'b0);
    for (int i = 4; i >= 0; i--) step(ra[i], 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step((op == 2'b01) ? 1'b0 : 1'b1, is_rd, 1'b0, 1'b0);
    for (int i = 15; i >= 0; i--) begin
      step((op == 2'b01) ? wd[i] : 1'b1, is_rd, rv[i], 1'b0);
      @(negedge mdc);
      rd = {rd[14:0], mdio_out};
    end
    rs_ev = is_wr && (ra == 5'd0) && wd[9] && !wd[15];
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, rs_ev);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    if (is_wr && (ra == 5'd0)) m_ctrl = wd[15] ? 16'h3000 : (wd & 16'h7D80);
    if (is_rd) chk(req, rd, rv);
  endtask

  task automatic do_reset(input logic [4:0] s);
    chk_en     = 1'b0;
    rst_n      = 1'b0;
    mdio_in    = 1'b1;
    strap_addr = s;
    m_strap    = s;
    m_ctrl     = 16'h3000;
    repeat (4) @(posedge mdc);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge mdc);
    @(negedge mdc);
    chk("R2 reset oe", {15'b0, mdio_oe}, 16'h0);
    chk("R8 reset restart", {15'b0, aneg_restart}, 16'h0);
    exp_oe  = 1'b0;
    exp_rst = 1'b0;
    chk_en  = 1'b1;
  endtask

  initial begin
    #600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    link_up   = 1'b1;
    aneg_done = 1'b0;
    do_reset(5'h0B);

    frame(32, 2'b10, 5'h0B, 5'd0, 16'h0, 1'b1, "R6 ctrl default", got);
    chk("R6 ctrl default value", got, 16'h3000);
    frame(32, 2'b10, 5'h0B, 5'd1, 16'h0, 1'b1, "R9 status link", got);
    chk("R9 status value", got, 16'h780D);
    aneg_done = 1'b1;
    link_up   = 1'b0;
    frame(32, 2'b10, 5'h0B, 5'd1, 16'h0, 1'b1, "R9 status aneg", got);
    frame(32, 2'b10, 5'h0B, 5'd2, 16'h0, 1'b1, "R10 id hi", got);
    frame(32, 2'b01, 5'h0B, 5'd3, 16'hFFFF, 1'b1, "R10 id write", got);
    frame(32, 2'b10, 5'h0B, 5'd3, 16'h0, 1'b1, "R10 id lo", got);
    chk("R10 id lo value", got, 16'h63D1);
    frame(32, 2'b10, 5'h0B, 5'd25, 16'h0, 1'b1, "R4 strap fast", got);
    chk("R4 strap value", got, 16'h000B);

    frame(32, 2'b01, 5'h0B, 5'd0, 16'h4DFF, 1'b1, "R6 ctrl write", got);
    frame(32, 2'b10, 5'h0B, 5'd0, 16'h0, 1'b1, "R6 ctrl readback", got);
    chk("R6 ctrl masked", got, 16'h4D80);
    frame(32, 2'b10, 5'h0B, 5'd25, 16'h0, 1'b1, "R4 strap slow", got);
    chk("R4 slow bit", got, 16'h004B);

    frame(32, 2'b01, 5'h0B, 5'd0, 16'h1200, 1'b1, "R8 restart write", got);
    frame(32, 2'b10, 5'h0B, 5'd0, 16'h0, 1'b1, "R8 restart self-clear", got);
    chk("R8 bit9 reads 0", got, 16'h1000);

    frame(32, 2'b01, 5'h0B, 5'd0, 16'hC6FF, 1'b1, "R7 soft reset", got);
    frame(32, 2'b10, 5'h0B, 5'd0, 16'h0, 1'b1, "R7 after soft reset", got);
    chk("R7 ctrl default", got, 16'h3000);

    frame(32, 2'b01, 5'h00, 5'd0, 16'h2100, 1'b1, "R3 broadcast write", got);
    frame(32, 2'b10, 5'h0B, 5'd0, 16'h0, 1'b1, "R3 broadcast readback", got);
    chk("R3 broadcast value", got, 16'h2100);
    frame(32, 2'b01, 5'h05, 5'd0, 16'h0000, 1'b1, "R3 foreign write", got);
    frame(32, 2'b10, 5'h05, 5'd0, 16'h0, 1'b1, "R3 foreign read", got);
    frame(32, 2'b10, 5'h00, 5'd0, 16'h0, 1'b1, "R3 ctrl kept", got);
    chk("R3 ctrl unchanged", got, 16'h2100);

    frame(32, 2'b01, 5'h0B, 5'd7, 16'hFFFF, 1'b1, "R11 reserved write", got);
    frame(32, 2'b10, 5'h0B, 5'd7, 16'h0, 1'b1, "R11 reserved read", got);
    chk("R11 reserved zero", got, 16'h0000);
    frame(32, 2'b10, 5'h0B, 5'd0, 16'h0, 1'b1, "R11 ctrl kept", got);
    chk("R11 ctrl unchanged", got, 16'h2100);

    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    frame(31, 2'b10, 5'h0B, 5'd0, 16'h0, 1'b0, "R1 short preamble", got);
    frame(32, 2'b10, 5'h0B, 5'd2, 16'h0, 1'b1, "R1 full preamble", got);
    chk("R1 recovery value", got, 16'h0A5C);

    frame(32, 2'b00, 5'h0B, 5'd0, 16'h0, 1'b1, "R12 opcode 00", got);
    frame(32, 2'b11, 5'h0B, 5'd0, 16'h0000, 1'b1, "R12 opcode 11", got);
    frame(32, 2'b10, 5'h0B, 5'd0, 16'h0, 1'b1, "R12 ctrl kept", got);
    chk("R12 ctrl unchanged", got, 16'h2100);

    do_reset(5'h00);
    frame(32, 2'b10, 5'h00, 5'd0, 16'h0, 1'b1, "R5 iso forced", got);
    chk("R5 iso default", got, 16'h3400);
    frame(32, 2'b01, 5'h00, 5'd0, 16'h3000, 1'b1, "R5 iso clear attempt", got);
    frame(32, 2'b10, 5'h00, 5'd0, 16'h0, 1'b1, "R5 iso still set", got);
    chk("R5 iso sticky", got, 16'h3400);
    frame(32, 2'b10, 5'h00, 5'd25, 16'h0, 1'b1, "R4 zero strap", got);
    chk("R4 zero strap value", got, 16'h0000);

    repeat (4) step(1'b1, 1'b0, 1'b0, 1'b0);
    chk_en = 1'b0;
    done   = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule